// File: doc/BRIEF.md
# Release-Aware Writeback Grant Arbiter

Several acquire-side transaction trackers share a single writeback engine. Each tracker that needs an eviction raises a request carrying a payload (the block to evict, for example). This block picks one requester in rotating order and forwards its request to the writeback engine. It returns a grant to that tracker in the cycle the engine accepts the request.

The arbiter must not hand the writeback engine to an acquire tracker while voluntary-release work is under way. Otherwise a release waiting for a channel could wait on an eviction that is itself waiting on that same channel. Each release tracker reports three things: an incoming release is being presented to it, it is busy, or it is being allocated. Any one of these from any release tracker closes a gate. While the gate is closed, both the request valid toward the engine and the grant back to the trackers are held low. No tracker can then believe it holds the engine when it does not.

The round-robin pointer is the only state register. It holds the index of the last tracker that was actually granted. The output process classifies every cycle into one of four named phases:
- PH_IDLE: no acquire tracker is requesting.
- PH_GATED: there are requests, but the release gate is closed.
- PH_OFFER: a request is presented and the engine is not ready.
- PH_GRANT: a request is presented and the engine is ready, so a handshake occurs.

The pointer has two transitions:
- hold: taken in PH_IDLE, PH_GATED and PH_OFFER.
- advance: taken in PH_GRANT, where the pointer moves to the granted index.

Top module: `wb_grant_arbiter`

## Requirements
- R1: The release gate is open only when, for every release tracker, the incoming-release flag, the busy flag and the allocation flag are all low. Any one of these flags high closes the gate in the same cycle.
- R2: `wb_req_valid` is high exactly when at least one acquire tracker requests and the gate is open.
- R3: In any cycle, at most one bit of `acq_req_ready` is high. A bit is high only for a requesting tracker, and only when `wb_req_valid` and `wb_req_ready` are both high.
- R4: While the gate is closed, no grant is given, even when `wb_req_ready` is high.
- R5: Bit i of the acquire vectors belongs to tracker i. After a grant to tracker i, priority starts at tracker i+1 and wraps from N_ACQ-1 back to 0. With all trackers requesting, successive grants therefore step 0, 1, 2, 3, 0 (for N_ACQ = 4).
- R6: The pointer changes only on a completed handshake. Cycles that are gated, cycles where the engine is not ready, and idle cycles leave the next winner unchanged.
- R7: `wb_req_data` equals the payload of the tracker selected this cycle. Tracker i's payload occupies bits [i*DATA_W +: DATA_W] of `acq_req_data`.
- R8: After reset, with no requests, `wb_req_valid` and all grants are low. When every tracker requests, tracker 0 wins first.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| acq_req_valid | input | N_ACQ | Writeback request from each acquire tracker |
| acq_req_data | input | N_ACQ*DATA_W | Request payloads, tracker i at [i*DATA_W +: DATA_W] |
| acq_req_ready | output | N_ACQ | Grant: high for the tracker whose request is accepted this cycle |
| wb_req_valid | output | 1 | Request presented to the writeback engine |
| wb_req_data | output | DATA_W | Payload of the selected tracker |
| wb_req_ready | input | 1 | Writeback engine accepts a request |
| rel_in_valid | input | N_REL | Incoming release presented to each release tracker |
| rel_busy | input | N_REL | Release tracker is occupied |
| rel_alloc | input | N_REL | Release tracker is being allocated this cycle |

## Verification
The bench first drives all four trackers requesting continuously. This separates a true rotation from fixed priority. It also confirms that tracker 0 wins first out of reset. It then closes the gate with each release flag in turn (incoming, busy, allocate) on different trackers, while the engine stays ready. This shows that each flag alone blocks both valid and grant, and that the rotation resumes exactly where it stopped. Stalls with the engine not ready tell apart a pointer that moves on offer from one that moves only on handshake. Sparse request patterns such as trackers 1 and 3 only check that the wrap-around skips idle trackers and that the forwarded payload follows the winner.

// File: rtl/wb_grant_arbiter_pkg.sv
package wb_grant_arbiter_pkg;

    typedef enum logic [1:0] {
        PH_IDLE  = 2'd0,
        PH_GATED = 2'd1,
        PH_OFFER = 2'd2,
        PH_GRANT = 2'd3
    } arb_phase_e;

endpackage

// File: rtl/wb_release_gate.sv
module wb_release_gate #(
    parameter int N_REL = 2
) (
    input  logic [N_REL-1:0] rel_in_valid,
    input  logic [N_REL-1:0] rel_busy,
    input  logic [N_REL-1:0] rel_alloc,
    output logic             gate_open
);
    logic [N_REL-1:0] quiet;

    // One quiet bit per release tracker: nothing arriving, nothing held, nothing being set up.
    for (genvar g = 0; g < N_REL; g++) begin : g_quiet
        assign quiet[g] = !rel_in_valid[g] && !rel_busy[g] && !rel_alloc[g];
    end

    assign gate_open = &quiet;
endmodule

// File: rtl/wb_rr_pick.sv
module wb_rr_pick #(
    parameter int N     = 4,
    parameter int PTR_W = (N > 1) ? $clog2(N) : 1
) (
    input  logic [N-1:0]     req,
    input  logic [PTR_W-1:0] last,
    output logic             any,
    output logic [PTR_W-1:0] idx
);
    always_comb begin
        any = 1'b0;
        idx = '0;
        // Walk from farthest to nearest so that the nearest requester after 'last' wins.
        for (int k = N; k >= 1; k--) begin
            int j;
            j = (int'(last) + k) % N;
            if (req[j]) begin
                any = 1'b1;
                idx = PTR_W'(j);
            end
        end
    end
endmodule

// File: rtl/wb_payload_mux.sv
module wb_payload_mux #(
    parameter int N      = 4,
    parameter int DATA_W = 32,
    parameter int PTR_W  = (N > 1) ? $clog2(N) : 1
) (
    input  logic [N*DATA_W-1:0] data_in,
    input  logic [PTR_W-1:0]    sel,
    output logic [DATA_W-1:0]   data_out
);
    always_comb begin
        data_out = '0;
        for (int i = 0; i < N; i++) begin
            if (sel == PTR_W'(i)) data_out = data_in[i*DATA_W +: DATA_W];
        end
    end
endmodule

// File: rtl/wb_grant_arbiter.sv
module wb_grant_arbiter
    import wb_grant_arbiter_pkg::*;
#(
    parameter int N_ACQ  = 4,
    parameter int N_REL  = 2,
    parameter int DATA_W = 32
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic [N_ACQ-1:0]        acq_req_valid,
    input  logic [N_ACQ*DATA_W-1:0] acq_req_data,
    output logic [N_ACQ-1:0]        acq_req_ready,
    output logic                    wb_req_valid,
    output logic [DATA_W-1:0]       wb_req_data,
    input  logic                    wb_req_ready,
    input  logic [N_REL-1:0]        rel_in_valid,
    input  logic [N_REL-1:0]        rel_busy,
    input  logic [N_REL-1:0]        rel_alloc
);
    localparam int PTR_W = (N_ACQ > 1) ? $clog2(N_ACQ) : 1;
    localparam logic [PTR_W-1:0] PTR_RESET = PTR_W'(N_ACQ - 1);

    logic             gate_open;
    logic             pick_any;
    logic [PTR_W-1:0] pick_idx;
    logic [PTR_W-1:0] last_q;
    arb_phase_e       phase;

    wb_release_gate #(.N_REL(N_REL)) u_gate (
        .rel_in_valid (rel_in_valid),
        .rel_busy     (rel_busy),
        .rel_alloc    (rel_alloc),
        .gate_open    (gate_open)
    );

    wb_rr_pick #(.N(N_ACQ), .PTR_W(PTR_W)) u_pick (
        .req  (acq_req_valid),
        .last (last_q),
        .any  (pick_any),
        .idx  (pick_idx)
    );

    wb_payload_mux #(.N(N_ACQ), .DATA_W(DATA_W), .PTR_W(PTR_W)) u_mux (
        .data_in  (acq_req_data),
        .sel      (pick_idx),
        .data_out (wb_req_data)
    );

    // Cycle classification.
    always_comb begin
        if (!pick_any)          phase = PH_IDLE;
        else if (!gate_open)    phase = PH_GATED;
        else if (!wb_req_ready) phase = PH_OFFER;
        else                    phase = PH_GRANT;
    end

    // Output process: valid and grant both pass through the gate.
    always_comb begin
        wb_req_valid  = 1'b0;
        acq_req_ready = '0;
        unique case (phase)
            PH_IDLE, PH_GATED: ;
            PH_OFFER: wb_req_valid = 1'b1;
            PH_GRANT: begin
                wb_req_valid            = 1'b1;
                acq_req_ready[pick_idx] = 1'b1;
            end
            default: ;
        endcase
    end

    // State register: pointer to the last granted tracker; hold or advance.
    always_ff @(posedge clk) begin
        if (!rst_n)                 last_q <= PTR_RESET;
        else if (phase == PH_GRANT) last_q <= pick_idx;
    end
endmodule

// File: rtl/wb_grant_arbiter_chk.sv
module wb_grant_arbiter_chk #(
    parameter int N_ACQ  = 4,
    parameter int N_REL  = 2,
    parameter int DATA_W = 32
) (
    input logic                    clk,
    input logic                    rst_n,
    input logic [N_ACQ-1:0]        acq_req_valid,
    input logic [N_ACQ*DATA_W-1:0] acq_req_data,
    input logic [N_ACQ-1:0]        acq_req_ready,
    input logic                    wb_req_valid,
    input logic [DATA_W-1:0]       wb_req_data,
    input logic                    wb_req_ready,
    input logic [N_REL-1:0]        rel_in_valid,
    input logic [N_REL-1:0]        rel_busy,
    input logic [N_REL-1:0]        rel_alloc
);
    logic              shut;
    logic [DATA_W-1:0] granted_data;
    logic [N_ACQ-1:0]  grant_rot;

    assign shut = (|rel_in_valid) || (|rel_busy) || (|rel_alloc);

    always_comb begin
        granted_data = '0;
        for (int i = 0; i < N_ACQ; i++)
            if (acq_req_ready[i]) granted_data = acq_req_data[i*DATA_W +: DATA_W];
    end

    always_comb begin
        for (int i = 0; i < N_ACQ; i++) grant_rot[(i + 1) % N_ACQ] = acq_req_ready[i];
    end

    a_r1_shut_blocks_valid: assert property (@(posedge clk) disable iff (!rst_n)
        shut |-> !wb_req_valid);

    a_r2_open_request_offers: assert property (@(posedge clk) disable iff (!rst_n)
        (!shut && (|acq_req_valid)) |-> wb_req_valid);

    a_r2_no_request_no_valid: assert property (@(posedge clk) disable iff (!rst_n)
        !(|acq_req_valid) |-> !wb_req_valid);

    a_r3_single_grant: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(acq_req_ready));

    a_r3_grant_is_handshake: assert property (@(posedge clk) disable iff (!rst_n)
        (|acq_req_ready) |-> (wb_req_valid && wb_req_ready && (|(acq_req_ready & acq_req_valid))));

    a_r4_shut_no_grant: assert property (@(posedge clk) disable iff (!rst_n)
        shut |-> (acq_req_ready == '0));

    a_r5_rotation: assert property (@(posedge clk) disable iff (!rst_n)
        ((|acq_req_ready) && (&acq_req_valid)) |=>
            (((&acq_req_valid) && (|acq_req_ready)) |-> (acq_req_ready == $past(grant_rot))));

    a_r7_payload_follows_winner: assert property (@(posedge clk) disable iff (!rst_n)
        (|acq_req_ready) |-> (wb_req_data == granted_data));
endmodule

bind wb_grant_arbiter wb_grant_arbiter_chk #(
    .N_ACQ(N_ACQ), .N_REL(N_REL), .DATA_W(DATA_W)
) u_chk (
    .clk(clk), .rst_n(rst_n),
    .acq_req_valid(acq_req_valid), .acq_req_data(acq_req_data),
    .acq_req_ready(acq_req_ready), .wb_req_valid(wb_req_valid),
    .wb_req_data(wb_req_data), .wb_req_ready(wb_req_ready),
    .rel_in_valid(rel_in_valid), .rel_busy(rel_busy), .rel_alloc(rel_alloc)
);

// File: tb/wb_grant_arbiter_test.sv
module wb_grant_arbiter_test;
    localparam int NA = 4;
    localparam int NR = 2;
    localparam int DW = 16;

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic [NA-1:0]     acq_req_valid = '0;
    logic [NA*DW-1:0]  acq_req_data = '0;
    logic [NA-1:0]     acq_req_ready;
    logic              wb_req_valid;
    logic [DW-1:0]     wb_req_data;
    logic              wb_req_ready = 1'b0;
    logic [NR-1:0]     rel_in_valid = '0;
    logic [NR-1:0]     rel_busy = '0;
    logic [NR-1:0]     rel_alloc = '0;

    always #5 clk = ~clk;

    wb_grant_arbiter #(.N_ACQ(NA), .N_REL(NR), .DATA_W(DW)) uut (
        .clk(clk), .rst_n(rst_n),
        .acq_req_valid(acq_req_valid), .acq_req_data(acq_req_data),
        .acq_req_ready(acq_req_ready), .wb_req_valid(wb_req_valid),
        .wb_req_data(wb_req_data), .wb_req_ready(wb_req_ready),
        .rel_in_valid(rel_in_valid), .rel_busy(rel_busy), .rel_alloc(rel_alloc)
    );

    typedef struct {
        logic          valid;
        logic [NA-1:0] grant;
        logic [DW-1:0] data;
        string         req;
    } exp_t;

    exp_t q[$];
    event sample_ev;
    int   checks = 0;
    int   failures = 0;
    int   model_last = NA - 1;
    int   stamp = 0;
    bit   done = 0;

    // Monitor: pops one expected item per sample and compares against the ports.
    initial begin
        forever begin
            @(sample_ev);
            while (q.size() > 0) begin
                exp_t e;
                e = q.pop_front();
                checks++;
                if (wb_req_valid !== e.valid) begin
                    failures++;
                    $display("FAIL %s valid actual=%b expected=%b", e.req, wb_req_valid, e.valid);
                end
                checks++;
                if (acq_req_ready !== e.grant) begin
                    failures++;
                    $display("FAIL %s grant actual=%b expected=%b", e.req, acq_req_ready, e.grant);
                end
                if (e.valid) begin
                    checks++;
                    if (wb_req_data !== e.data) begin
                        failures++;
                        $display("FAIL %s data actual=%h expected=%h", e.req, wb_req_data, e.data);
                    end
                end
            end
        end
    end

    // Driver: one cycle of stimulus, expectation built from the requirements.
    task automatic step(input logic [NA-1:0] v, input logic [NR-1:0] ri,
                        input logic [NR-1:0] rb, input logic [NR-1:0] ra,
                        input logic rdy, input string req);
        exp_t e;
        int   win;
        bit   shut;
        @(negedge clk);
        stamp++;
        acq_req_valid = v;
        for (int i = 0; i < NA; i++) acq_req_data[i*DW +: DW] = DW'(16'hC000 + i * 16'h100 + stamp);
        rel_in_valid = ri;
        rel_busy     = rb;
        rel_alloc    = ra;
        wb_req_ready = rdy;
        shut = (ri != 0) || (rb != 0) || (ra != 0);
        win = -1;
        for (int k = 1; k <= NA; k++) begin
            int j;
            j = (model_last + k) % NA;
            if (win < 0 && v[j]) win = j;
        end
        e.req   = req;
        e.valid = (win >= 0) && !shut;
        e.grant = '0;
        e.data  = '0;
        if (e.valid) e.data = DW'(16'hC000 + win * 16'h100 + stamp);
        if (e.valid && rdy) e.grant[win] = 1'b1;
        #2;
        q.push_back(e);
        -> sample_ev;
        #1;
        if (e.valid && rdy) model_last = win;
    endtask

    initial begin
        repeat (3) @(posedge clk);
        // R8: reset state observed while reset is still asserted, then released
        #2;
        checks++;
        if (wb_req_valid !== 1'b0 || acq_req_ready !== '0) begin
            failures++;
            $display("FAIL R8 reset outputs actual=%b/%b expected=0/0", wb_req_valid, acq_req_ready);
        end
        @(negedge clk) rst_n = 1'b1;
        step(4'b0000, 0, 0, 0, 1, "R8");
        // R5 and R8: full rotation with everyone requesting, tracker 0 first
        for (int n = 0; n < 5; n++) step(4'b1111, 0, 0, 0, 1, "R5");
        // R1/R4: each release flag alone shuts the gate, engine ready
        step(4'b1111, 2'b10, 0, 0, 1, "R4");
        step(4'b1111, 0, 2'b01, 0, 1, "R1");
        step(4'b1111, 0, 0, 2'b10, 1, "R1");
        step(4'b1111, 2'b11, 2'b11, 2'b11, 1, "R4");
        // R6: rotation resumes where it stopped
        step(4'b1111, 0, 0, 0, 1, "R6");
        // R6: engine not ready, pointer holds
        step(4'b1111, 0, 0, 0, 0, "R6");
        step(4'b1111, 0, 0, 0, 0, "R6");
        step(4'b1111, 0, 0, 0, 1, "R6");
        // R2: offer without ready, single requester
        step(4'b0100, 0, 0, 0, 0, "R2");
        step(4'b0000, 0, 0, 0, 1, "R2");
        // R5/R7: sparse requesters, wrap skips idle trackers
        for (int n = 0; n < 4; n++) step(4'b1010, 0, 0, 0, 1, "R7");
        step(4'b0001, 0, 0, 0, 1, "R5");
        step(4'b1001, 0, 0, 0, 1, "R5");
        // R3: idle-gated mix
        step(4'b0110, 2'b01, 0, 0, 1, "R3");
        step(4'b0110, 0, 0, 0, 1, "R3");
        step(4'b0110, 0, 0, 0, 1, "R3");
        @(negedge clk);
        if (!done) begin
            done = 1;
            $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    initial begin
        #(10 * 200000);
        if (!done) begin
            done = 1;
            checks++;
            failures++;
            $display("FAIL watchdog expired actual=running expected=finished");
            $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end
endmodule